// File: doc/BRIEF.md
# Column Driver Line Capture

This block is the digital front end of one column-driver chip in a display panel. It gathers a full display line of 8-bit gray values into an internal line register, then hands the finished line to an output latch that feeds the analog stage. Several chips sit in a chain. Each chip waits for a start pulse, takes its share of the line, and then passes a start pulse on to its neighbour. A direction input selects which start pin acts as the input and which one acts as the output. It also selects whether the line fills from the lowest channel upward or from the highest channel downward.

Capture begins on a single clock after the start is seen. From then on, each clock edge stores one group of six gray values, delivered on two 24-bit ports. After 64 groups the line is full. Capture switches itself off a fixed number of clocks after the start, so extra clocks do not disturb the stored line. A rising edge on the strobe copies the line into the output latch and cancels any capture in progress.

Top module: `column_capture`

## Requirements
- R1: A capture edge stores one group of six values. For j = 0..2, value j is `port1Data[8j+7:8j]`. For j = 3..5, value j is `port2Data[8(j-3)+7:8(j-3)]`. Bit 7 of each value is its MSB. Channel c of the line appears on `lineOut[8c+7:8c]`.
- R2: The active start input must be sampled high on a rising clock edge. Capture begins on the edge after that one. The k-th capture edge (k counted from 1) writes slot k-1.
- R3: With `dirRight` = 1, the start input is `startRightIn`, value j of slot g goes to channel 6g+j, the cascade goes out on `startLeftOut`, and `startLeftOe` = 1, `startRightOe` = 0. With `dirRight` = 0, the start input is `startLeftIn`, the value goes to channel 383-(6g+j), the cascade goes out on `startRightOut`, and the enables are swapped.
- R4: A line is 64 groups, and these fill all 384 channels exactly once.
- R5: The cascade output is high for exactly one clock cycle, in the cycle that follows the edge that writes the last slot. The other start output stays low.
- R6: A start input held high for several clocks counts as one start, on its first high edge.
- R7: Edges after the 64th capture edge write nothing. Capture stops on the 66th edge after the start.
- R8: A start that rises while capture is active is ignored, and this includes the 66th edge after the start. A start on the 67th edge or later is accepted and begins again at slot 0.
- R9: A rising strobe edge, sampled by the clock, does three things. It copies the line register to `lineOut`, visible after that edge. It ends capture, so data on that edge and on later edges is not stored until the next start. Outside reset and strobe edges, `lineOut` does not change.
- R10: When `rstN` is low at a clock edge, the line register, the output latch and the capture state are cleared, and both cascade outputs go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| dirRight | input | 1 | Fill direction and start pin roles |
| startRightIn | input | 1 | Start pulse from the right-hand pin |
| startLeftIn | input | 1 | Start pulse from the left-hand pin |
| strobe | input | 1 | Line latch strobe, acts on its rising edge |
| port1Data | input | 24 | Gray values 0 to 2 of a group |
| port2Data | input | 24 | Gray values 3 to 5 of a group |
| startRightOut | output | 1 | Cascade pulse on the right-hand pin |
| startLeftOut | output | 1 | Cascade pulse on the left-hand pin |
| startRightOe | output | 1 | Right-hand pin acts as an output |
| startLeftOe | output | 1 | Left-hand pin acts as an output |
| lineOut | output | 3072 | Latched line, 384 channels of 8 bits |

## Verification
The hardest conditions to reach from the ports are the edges of the self-halt window and a strobe that arrives partway through a line. In the window test, a second start pulse is placed exactly on the 66th edge in one run and on the 67th edge in another. Clocks carrying distinct data follow each pulse, so an accepted restart visibly overwrites the low slots. The mid-line test raises the strobe on edge 30 and keeps feeding fresh data afterwards. Two consecutive latches must then show the same half-new, half-old line.

// File: rtl/colcap_pkg.sv
package colcap_pkg;
  parameter int VAL_W         = 8;
  parameter int VALS_PER_PORT = 3;
  parameter int GROUPS        = 64;
  parameter int HALT_CLKS     = 66;

  localparam int VALS     = 2 * VALS_PER_PORT;
  localparam int PORT_W   = VALS_PER_PORT * VAL_W;
  localparam int GRP_W    = VALS * VAL_W;
  localparam int CHANNELS = GROUPS * VALS;
  localparam int LINE_W   = CHANNELS * VAL_W;
  localparam int CH_W     = $clog2(CHANNELS);
  localparam int PTR_W    = $clog2(GROUPS + 1);
  localparam int CNT_W    = $clog2(HALT_CLKS + 1);

  typedef struct packed {
    logic             writeEn;
    logic             latchEn;
    logic             fillRight;
    logic [PTR_W-1:0] slot;
  } capCtrl_t;
endpackage

// File: rtl/captureCtrl.sv
module captureCtrl
  import colcap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     dirRight,
  input  logic     startRightIn,
  input  logic     startLeftIn,
  input  logic     strobe,
  output capCtrl_t ctrl,
  output logic     startRightOut,
  output logic     startLeftOut,
  output logic     startRightOe,
  output logic     startLeftOe
);
  logic             startIn, startPrev, startRise;
  logic             strobePrev, strobeRise;
  logic             active, fillRight, cascadeQ, slotOpen;
  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;

  assign startIn    = dirRight ? startRightIn : startLeftIn;
  assign startRise  = startIn & ~startPrev;
  assign strobeRise = strobe & ~strobePrev;
  assign slotOpen   = (ptr < PTR_W'(GROUPS));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPrev  <= 1'b0;
      strobePrev <= 1'b0;
      active     <= 1'b0;
      fillRight  <= 1'b1;
      cascadeQ   <= 1'b0;
      ptr        <= '0;
      cnt        <= '0;
    end else begin
      startPrev  <= startIn;
      strobePrev <= strobe;
      cascadeQ   <= 1'b0;
      if (strobeRise) begin
        active <= 1'b0;
        ptr    <= '0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(HALT_CLKS - 1)) active <= 1'b0;
        if (slotOpen) begin
          ptr <= ptr + 1'b1;
          if (ptr == PTR_W'(GROUPS - 1)) cascadeQ <= 1'b1;
        end
      end else if (startRise) begin
        active    <= 1'b1;
        cnt       <= '0;
        ptr       <= '0;
        fillRight <= dirRight;
      end
    end
  end

  assign ctrl.writeEn   = active & ~strobeRise & slotOpen;
  assign ctrl.latchEn   = strobeRise;
  assign ctrl.fillRight = fillRight;
  assign ctrl.slot      = ptr;

  assign startLeftOut  = cascadeQ & fillRight;
  assign startRightOut = cascadeQ & ~fillRight;
  assign startLeftOe   = dirRight;
  assign startRightOe  = ~dirRight;
endmodule

// File: rtl/lineStore.sv
module lineStore
  import colcap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  capCtrl_t          ctrl,
  input  logic [PORT_W-1:0] port1Data,
  input  logic [PORT_W-1:0] port2Data,
  output logic [LINE_W-1:0] lineOut
);
  logic [VAL_W-1:0] lineReg  [CHANNELS];
  logic [VAL_W-1:0] latchReg [CHANNELS];
  logic [GRP_W-1:0] grp;
  logic [CH_W-1:0]  base [VALS];
  logic [CH_W-1:0]  chan [VALS];

  assign grp = {port2Data, port1Data};

  always_comb begin
    for (int j = 0; j < VALS; j++) begin
      base[j] = CH_W'(ctrl.slot) * CH_W'(VALS) + CH_W'(j);
      chan[j] = ctrl.fillRight ? base[j] : (CH_W'(CHANNELS - 1) - base[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < CHANNELS; c++) begin
        lineReg[c]  <= '0;
        latchReg[c] <= '0;
      end
    end else begin
      if (ctrl.latchEn) begin
        for (int c = 0; c < CHANNELS; c++) latchReg[c] <= lineReg[c];
      end
      if (ctrl.writeEn) begin
        for (int j = 0; j < VALS; j++) lineReg[chan[j]] <= grp[j*VAL_W +: VAL_W];
      end
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_flat
    assign lineOut[c*VAL_W +: VAL_W] = latchReg[c];
  end
endmodule

// File: rtl/column_capture.sv
module column_capture
  import colcap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dirRight,
  input  logic              startRightIn,
  input  logic              startLeftIn,
  input  logic              strobe,
  input  logic [PORT_W-1:0] port1Data,
  input  logic [PORT_W-1:0] port2Data,
  output logic              startRightOut,
  output logic              startLeftOut,
  output logic              startRightOe,
  output logic              startLeftOe,
  output logic [LINE_W-1:0] lineOut
);
  capCtrl_t ctrlBus;

  captureCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .dirRight     (dirRight),
    .startRightIn (startRightIn),
    .startLeftIn  (startLeftIn),
    .strobe       (strobe),
    .ctrl         (ctrlBus),
    .startRightOut(startRightOut),
    .startLeftOut (startLeftOut),
    .startRightOe (startRightOe),
    .startLeftOe  (startLeftOe)
  );

  lineStore u_store (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrlBus),
    .port1Data(port1Data),
    .port2Data(port2Data),
    .lineOut  (lineOut)
  );
endmodule

// File: rtl/colcap_checker.sv
module colcap_checker
  import colcap_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              startRightOut,
  input logic              startLeftOut,
  input logic [LINE_W-1:0] lineOut,
  input capCtrl_t          ctrlBus
);
  logic rstSeen;
  logic wasReset;

  always_ff @(posedge clk) begin
    rstSeen  <= !rstN;
    wasReset <= !rstN || rstSeen;
  end

  // R3: only one start pin carries a cascade pulse
  assert_single_pin_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(startRightOut && startLeftOut));

  // R5: the cascade pulse lasts one cycle
  assert_one_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startRightOut || startLeftOut) |=> !(startRightOut || startLeftOut));

  // R5: the cascade pulse follows a datapath write
  assert_pulse_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startRightOut || startLeftOut) |-> $past(ctrlBus.writeEn));

  // R9: the latched line changes only after a latch command
  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wasReset === 1'b0 && !$past(ctrlBus.latchEn)) |-> $stable(lineOut));

  // R10: a reset edge leaves the latch cleared
  always @(negedge clk) begin
    if (rstSeen === 1'b1) begin
      assert_reset_clear_R10: assert (lineOut == '0);
    end
  end
endmodule

bind column_capture colcap_checker chk (
  .clk          (clk),
  .rstN         (rstN),
  .startRightOut(startRightOut),
  .startLeftOut (startLeftOut),
  .lineOut      (lineOut),
  .ctrlBus      (ctrlBus)
);

// File: tb/column_capture_test.sv
`timescale 1ns/1ps
module column_capture_test;
  import colcap_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              dirRight = 1'b1;
  logic              startRightIn = 1'b0;
  logic              startLeftIn = 1'b0;
  logic              strobe = 1'b0;
  logic [PORT_W-1:0] port1Data = '0;
  logic [PORT_W-1:0] port2Data = '0;
  logic              startRightOut, startLeftOut, startRightOe, startLeftOe;
  logic [LINE_W-1:0] lineOut;

  int   errs = 0;
  int   checks = 0;
  bit   finished = 0;
  event due;
  logic [VAL_W-1:0]  expLine [CHANNELS];
  logic [LINE_W-1:0] expQ [$];
  string             tagQ [$];

  always #2 clk = ~clk;

  column_capture uut (
    .clk(clk), .rstN(rstN), .dirRight(dirRight),
    .startRightIn(startRightIn), .startLeftIn(startLeftIn), .strobe(strobe),
    .port1Data(port1Data), .port2Data(port2Data),
    .startRightOut(startRightOut), .startLeftOut(startLeftOut),
    .startRightOe(startRightOe), .startLeftOe(startLeftOe),
    .lineOut(lineOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [VAL_W-1:0] valOf(input int seed, input int k, input int j);
    return VAL_W'((seed * 53 + k * 7 + j * 29 + 1) & 255);
  endfunction

  // R1: value j of the group sits at bits 8j+7..8j of {port2Data, port1Data}
  function automatic logic [GRP_W-1:0] grpData(input int seed, input int k);
    logic [GRP_W-1:0] r;
    for (int j = 0; j < VALS; j++) r[j*VAL_W +: VAL_W] = valOf(seed, k, j);
    return r;
  endfunction

  // R3: channel mapping for each fill direction
  function automatic int chanOf(input logic dirR, input int g, input int j);
    return dirR ? (g * VALS + j) : (CHANNELS - 1 - (g * VALS + j));
  endfunction

  function automatic logic [LINE_W-1:0] flatExp();
    logic [LINE_W-1:0] r;
    for (int c = 0; c < CHANNELS; c++) r[c*VAL_W +: VAL_W] = expLine[c];
    return r;
  endfunction

  task automatic step(input logic sR, input logic sL, input logic stb, input logic [GRP_W-1:0] d);
    @(negedge clk);
    startRightIn = sR;
    startLeftIn  = sL;
    strobe       = stb;
    {port2Data, port1Data} = d;
  endtask

  task automatic pushLatch(input string tag);
    expQ.push_back(flatExp());
    tagQ.push_back(tag);
    -> due;
  endtask

  // Scoreboard monitor: compares each latched line one edge after its strobe
  initial begin
    forever begin
      logic [LINE_W-1:0] e;
      string             t;
      @(due);
      @(posedge clk);
      #1;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (lineOut !== e) begin
        errs++;
        for (int c = 0; c < CHANNELS; c++) begin
          if (lineOut[c*VAL_W +: VAL_W] !== e[c*VAL_W +: VAL_W]) begin
            $display("FAIL %s: channel %0d actual=%0h expected=%0h", t, c,
                     lineOut[c*VAL_W +: VAL_W], e[c*VAL_W +: VAL_W]);
            break;
          end
        end
      end
    end
  end

  task automatic runLine(input logic dirR, input int seed, input int nEdges, input int holdStart,
                         input int pulseAt, input int strobeAt, input string tag);
    int   capStart = 0;
    bit   stopped = 0;
    int   casK = -10;
    logic st;
    dirRight = dirR;
    step(dirR, !dirR, 1'b0, '0);
    for (int k = 1; k <= nEdges; k++) begin
      st = (k < holdStart) || (k == pulseAt);
      step(dirR & st, !dirR & st, k == strobeAt, grpData(seed, k));
      if (k == strobeAt) begin
        pushLatch({tag, " R9 mid-line strobe"});
        stopped = 1;
      end else if (!stopped) begin
        if (k == pulseAt && pulseAt >= HALT_CLKS + 1) capStart = k;
        else if (k - capStart >= 1 && k - capStart <= GROUPS) begin
          for (int j = 0; j < VALS; j++) expLine[chanOf(dirR, k - capStart - 1, j)] = valOf(seed, k, j);
        end
      end
      if (!stopped && capStart == 0 && k == GROUPS) begin
        @(posedge clk); #1;
        check({tag, " R5 cascade out"}, 32'(dirR ? startLeftOut : startRightOut), 32'd1);
        check({tag, " R5 other pin low"}, 32'(dirR ? startRightOut : startLeftOut), 32'd0);
        casK = k;
      end else if (k == casK + 1) begin
        @(posedge clk); #1;
        check({tag, " R5 pulse ends"}, 32'(startLeftOut | startRightOut), 32'd0);
      end
    end
    step(1'b0, 1'b0, 1'b1, '0);
    pushLatch({tag, " R9 line latch"});
    step(1'b0, 1'b0, 1'b0, '0);
    step(1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    for (int c = 0; c < CHANNELS; c++) expLine[c] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 latch zero", 32'(lineOut == '0), 32'd1);
    check("R10 cascade low", 32'(startLeftOut | startRightOut), 32'd0);
    check("R3 left pin is output", 32'(startLeftOe), 32'd1);
    check("R3 right pin is input", 32'(startRightOe), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2 R4 R7: right fill, extra edges carry data that must not land
    runLine(1'b1, 1, 70, 1, 0, 0, "right");
    // R3: left fill, cascade on the right pin
    runLine(1'b0, 2, 66, 1, 0, 0, "left");
    @(negedge clk);
    check("R3 right pin is output", 32'(startRightOe), 32'd1);
    check("R3 left pin is input", 32'(startLeftOe), 32'd0);
    // R6: start held for three clocks
    runLine(1'b1, 3, 66, 3, 0, 0, "held start R6");
    // R8: start inside the line ignored
    runLine(1'b0, 4, 66, 1, 20, 0, "mid start R8");
    // R8 R7: start on the 66th edge ignored
    runLine(1'b1, 5, 70, 1, 66, 0, "edge66 R8");
    // R8: start on the 67th edge restarts at slot 0
    runLine(1'b1, 6, 70, 1, 67, 0, "edge67 R8");
    // R9: strobe partway through the line
    runLine(1'b0, 7, 40, 1, 0, 30, "partial R9");

    // R10: reset in the middle of a line
    dirRight = 1'b1;
    step(1'b1, 1'b0, 1'b0, '0);
    for (int k = 1; k <= 10; k++) step(1'b0, 1'b0, 1'b0, grpData(8, k));
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10 latch cleared", 32'(lineOut == '0), 32'd1);
    rstN = 1'b1;
    for (int c = 0; c < CHANNELS; c++) expLine[c] = '0;
    step(1'b0, 1'b0, 1'b1, '0);
    pushLatch("R10 line register cleared");
    step(1'b0, 1'b0, 1'b0, '0);
    repeat (4) @(negedge clk);

    if (expQ.size() != 0) begin
      checks++;
      errs++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", expQ.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule